// File: doc/BRIEF.md
# Cartridge Directory Reader and Program Loader

The block walks a small byte-packed directory held at the bottom of a cartridge ROM, counts the entries a menu may show, and fetches the name of one chosen entry. On request it also copies the chosen program from the cartridge into system RAM, one byte at a time, by driving the ROM read port and the RAM write port itself. Before any byte is copied it checks that the program fits in RAM. A program that does not fit is refused with an error and RAM is left untouched.

A host issues one command at a time with `start`. It supplies a visible-entry index on `sel`, a RAM destination on `dst_base`, and on `load` a choice between copying and only looking. A menu calls the look-only form once per index to collect the entry count and the names. It then issues a load for the entry the user picks. When the command ends, `done` or `error` stays high until the next command.

Top module: `cart_loader`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `ram_we` and `rom_rd` are low, `entry_count` is 0 and `name_bytes` is all zeros.
- R2: ROM byte 0 holds the total number of entries. Entry i starts at byte 1 + i*S, where S = 4 + NAME_LEN + (1 if HAS_ATTR). Inside an entry come the program location (2 bytes, low byte first), the program length (2 bytes, low byte first), NAME_LEN name bytes, and the attribute byte last.
- R3: An attribute byte with bit 0 set marks the entry as hidden. `entry_count` reports only the entries that are not hidden. `sel` counts only those entries, in directory order.
- R4: When a command ends with `done`, name byte k of the selected entry is on `name_bytes[8k+7:8k]`. A new command clears `name_bytes` to zero.
- R5: If `sel` is greater than or equal to the visible count, the command ends with `error` and makes no RAM write. `entry_count` still shows the visible count.
- R6: A load writes RAM[dst_base+k] = ROM[location+k] for k = 0 to length-1, in ascending order, and then raises `done`.
- R7: A load whose dst_base + length is greater than RAM_BYTES ends with `error` and makes no RAM write. dst_base + length equal to RAM_BYTES is accepted.
- R8: A zero-length entry ends with `done` and makes no RAM write.
- R9: With `load` low, the command fetches the count and the name, ends with `done`, and makes no RAM write.
- R10: `done` and `error` are never high together. Each holds until the next accepted `start`. A `start` that arrives while `busy` is high is ignored.
- R11: At most one ROM read is in flight at a time, so `rom_rd` is never high in two consecutive cycles. Read data is taken ROM_LAT cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe, accepted only while idle |
| load | input | 1 | 1: copy the program; 0: count and name only |
| sel | input | 8 | Index among the visible entries |
| dst_base | input | RAM_AW | RAM address of the first copied byte |
| rom_rd | output | 1 | ROM read request |
| rom_addr | output | ROM_AW | ROM byte address |
| rom_data | input | 8 | ROM read data, valid ROM_LAT cycles after the request |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | RAM_AW | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| busy | output | 1 | A command is in progress |
| done | output | 1 | The last command completed |
| error | output | 1 | The last command was refused |
| entry_count | output | 8 | Number of visible entries |
| name_bytes | output | 8*NAME_LEN | Name of the selected entry, first byte in the low bits |

## Verification
A wrong directory pointer or field counter shows at the ports as a wrong name, a wrong `entry_count`, or RAM writes that go to the wrong addresses or carry the wrong bytes. The bench sees any of these in the same command. Each RAM write is compared against a scoreboard at the moment it appears, so a bad copy address is reported on its first write. A stray write in a refused or look-only command is reported the moment it appears. A fit check that goes the wrong way shows either as an error where `done` is expected or as writes at the RAM boundary.

// File: rtl/cart_loader_pkg.sv
package cart_loader_pkg;

   typedef enum logic [2:0] {
      LS_IDLE,
      LS_HDR,
      LS_SCAN,
      LS_PICK,
      LS_ENTRY,
      LS_FIT,
      LS_COPY
   } ld_state_t;

   localparam int FIXED_FIELDS = 4;

endpackage

// File: rtl/cl_rom_port.sv
module cl_rom_port #(
   parameter int AW  = 16,
   parameter int LAT = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [AW-1:0] req_addr,
   output logic          rom_rd,
   output logic [AW-1:0] rom_addr,
   input  logic [7:0]    rom_data,
   output logic          rsp_valid,
   output logic [7:0]    rsp_data
);

   assign rom_rd   = req;
   assign rom_addr = req_addr;
   assign rsp_data = rom_data;

   generate
      if (LAT == 1) begin : g_lat1
         logic vld_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vld_q <= 1'b0;
            else        vld_q <= req;
         end
         assign rsp_valid = vld_q;
      end else begin : g_latn
         logic [LAT-1:0] vld_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vld_q <= '0;
            else        vld_q <= {vld_q[LAT-2:0], req};
         end
         assign rsp_valid = vld_q[LAT-1];
      end
   endgenerate

endmodule

// File: rtl/cl_fit_check.sv
module cl_fit_check #(
   parameter int LW        = 16,
   parameter int RAM_AW    = 12,
   parameter int RAM_BYTES = 4096
) (
   input  logic [RAM_AW-1:0] base,
   input  logic [LW-1:0]     len,
   output logic              fits,
   output logic              empty
);

   localparam int SW = ((LW > RAM_AW) ? LW : RAM_AW) + 1;
   localparam logic [SW-1:0] LIMIT = SW'(RAM_BYTES);

   logic [SW-1:0] span_end;

   assign span_end = SW'(base) + SW'(len);
   assign fits     = (span_end <= LIMIT);
   assign empty    = (len == '0);

endmodule

// File: rtl/cl_name_buf.sv
module cl_name_buf #(
   parameter int NAME_LEN = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  wr,
   input  logic [3:0]            idx,
   input  logic [7:0]            din,
   output logic [NAME_LEN*8-1:0] name
);

   generate
      for (genvar k = 0; k < NAME_LEN; k++) begin : g_byte
         logic [7:0] byte_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          byte_q <= 8'h00;
            else if (clr)                        byte_q <= 8'h00;
            else if (wr && (idx == 4'(k)))       byte_q <= din;
         end
         assign name[8*k +: 8] = byte_q;
      end
   endgenerate

endmodule

// File: rtl/cart_loader.sv
module cart_loader
   import cart_loader_pkg::*;
#(
   parameter int ROM_AW    = 16,
   parameter int RAM_AW    = 12,
   parameter int RAM_BYTES = 4096,
   parameter int NAME_LEN  = 8,
   parameter int HAS_ATTR  = 1,
   parameter int ROM_LAT   = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  load,
   input  logic [7:0]            sel,
   input  logic [RAM_AW-1:0]     dst_base,
   output logic                  rom_rd,
   output logic [ROM_AW-1:0]     rom_addr,
   input  logic [7:0]            rom_data,
   output logic                  ram_we,
   output logic [RAM_AW-1:0]     ram_addr,
   output logic [7:0]            ram_wdata,
   output logic                  busy,
   output logic                  done,
   output logic                  error,
   output logic [7:0]            entry_count,
   output logic [NAME_LEN*8-1:0] name_bytes
);

   localparam int ENT_SIZE = FIXED_FIELDS + NAME_LEN + ((HAS_ATTR != 0) ? 1 : 0);
   localparam int ATTR_OFS = FIXED_FIELDS + NAME_LEN;
   localparam int LAST_FLD = FIXED_FIELDS + NAME_LEN - 1;

   generate
      if (NAME_LEN < 8 || NAME_LEN > 11) begin : g_bad_name
         $error("cart_loader: NAME_LEN must lie in 8..11");
      end
      if (ROM_LAT < 1) begin : g_bad_lat
         $error("cart_loader: ROM_LAT must be at least 1");
      end
      if (ROM_AW < 16) begin : g_bad_rom
         $error("cart_loader: ROM_AW must be at least 16");
      end
      if (RAM_BYTES < 1 || RAM_BYTES > (1 << RAM_AW)) begin : g_bad_ram
         $error("cart_loader: RAM_BYTES must fit in the RAM address space");
      end
   endgenerate

   ld_state_t           st;
   logic                pend;
   logic                cmd_load;
   logic [7:0]          sel_r;
   logic [RAM_AW-1:0]   dst_r;
   logic [7:0]          total;
   logic [7:0]          ent_i;
   logic [7:0]          vis_cnt;
   logic [ROM_AW-1:0]   ent_base;
   logic [ROM_AW-1:0]   found_base;
   logic [3:0]          fld;
   logic [15:0]         loc;
   logic [15:0]         len;
   logic [15:0]         copy_n;
   logic                done_r;
   logic                err_r;
   logic [7:0]          count_r;

   logic                want_rd;
   logic                req;
   logic [ROM_AW-1:0]   req_addr;
   logic                rsp_valid;
   logic [7:0]          rsp_data;
   logic                fits;
   logic                empty;
   logic                name_clr;
   logic                name_wr;
   logic [3:0]          name_idx;

   always_comb begin
      want_rd  = 1'b0;
      req_addr = '0;
      unique case (st)
         LS_HDR: begin
            want_rd  = 1'b1;
            req_addr = '0;
         end
         LS_SCAN: begin
            want_rd  = 1'b1;
            req_addr = ent_base + ROM_AW'(ATTR_OFS);
         end
         LS_ENTRY: begin
            want_rd  = 1'b1;
            req_addr = found_base + ROM_AW'(fld);
         end
         LS_COPY: begin
            want_rd  = 1'b1;
            req_addr = ROM_AW'(loc) + ROM_AW'(copy_n);
         end
         default: begin
            want_rd  = 1'b0;
            req_addr = '0;
         end
      endcase
   end

   assign req = want_rd && !pend;

   cl_rom_port #(
      .AW  (ROM_AW),
      .LAT (ROM_LAT)
   ) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .req_addr  (req_addr),
      .rom_rd    (rom_rd),
      .rom_addr  (rom_addr),
      .rom_data  (rom_data),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data)
   );

   cl_fit_check #(
      .LW        (16),
      .RAM_AW    (RAM_AW),
      .RAM_BYTES (RAM_BYTES)
   ) u_fit (
      .base  (dst_r),
      .len   (len),
      .fits  (fits),
      .empty (empty)
   );

   assign name_clr = (st == LS_IDLE) && start;
   assign name_wr  = (st == LS_ENTRY) && rsp_valid && (fld >= 4'(FIXED_FIELDS));
   assign name_idx = fld - 4'(FIXED_FIELDS);

   cl_name_buf #(
      .NAME_LEN (NAME_LEN)
   ) u_name (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (name_clr),
      .wr    (name_wr),
      .idx   (name_idx),
      .din   (rsp_data),
      .name  (name_bytes)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= LS_IDLE;
         pend       <= 1'b0;
         cmd_load   <= 1'b0;
         sel_r      <= '0;
         dst_r      <= '0;
         total      <= '0;
         ent_i      <= '0;
         vis_cnt    <= '0;
         ent_base   <= '0;
         found_base <= '0;
         fld        <= '0;
         loc        <= '0;
         len        <= '0;
         copy_n     <= '0;
         done_r     <= 1'b0;
         err_r      <= 1'b0;
         count_r    <= '0;
      end else begin
         if (req)       pend <= 1'b1;
         if (rsp_valid) pend <= 1'b0;

         unique case (st)
            LS_IDLE: begin
               if (start) begin
                  cmd_load <= load;
                  sel_r    <= sel;
                  dst_r    <= dst_base;
                  done_r   <= 1'b0;
                  err_r    <= 1'b0;
                  st       <= LS_HDR;
               end
            end

            LS_HDR: begin
               if (rsp_valid) begin
                  total    <= rsp_data;
                  ent_i    <= '0;
                  ent_base <= ROM_AW'(1);
                  if (HAS_ATTR != 0) begin
                     vis_cnt    <= '0;
                     found_base <= '0;
                     st         <= (rsp_data == 8'd0) ? LS_PICK : LS_SCAN;
                  end else begin
                     vis_cnt    <= rsp_data;
                     found_base <= ROM_AW'(1) + ROM_AW'(sel_r) * ROM_AW'(ENT_SIZE);
                     st         <= LS_PICK;
                  end
               end
            end

            LS_SCAN: begin
               if (rsp_valid) begin
                  if (!rsp_data[0]) begin
                     if (vis_cnt == sel_r) found_base <= ent_base;
                     vis_cnt <= vis_cnt + 8'd1;
                  end
                  ent_base <= ent_base + ROM_AW'(ENT_SIZE);
                  ent_i    <= ent_i + 8'd1;
                  if (ent_i == total - 8'd1) st <= LS_PICK;
               end
            end

            LS_PICK: begin
               count_r <= vis_cnt;
               fld     <= '0;
               if (sel_r >= vis_cnt) begin
                  err_r <= 1'b1;
                  st    <= LS_IDLE;
               end else begin
                  st    <= LS_ENTRY;
               end
            end

            LS_ENTRY: begin
               if (rsp_valid) begin
                  case (fld)
                     4'd0:    loc[7:0]  <= rsp_data;
                     4'd1:    loc[15:8] <= rsp_data;
                     4'd2:    len[7:0]  <= rsp_data;
                     4'd3:    len[15:8] <= rsp_data;
                     default: ;
                  endcase
                  fld <= fld + 4'd1;
                  if (fld == 4'(LAST_FLD)) st <= LS_FIT;
               end
            end

            LS_FIT: begin
               copy_n <= '0;
               if (!cmd_load || empty) begin
                  done_r <= 1'b1;
                  st     <= LS_IDLE;
               end else if (!fits) begin
                  err_r  <= 1'b1;
                  st     <= LS_IDLE;
               end else begin
                  st     <= LS_COPY;
               end
            end

            LS_COPY: begin
               if (rsp_valid) begin
                  copy_n <= copy_n + 16'd1;
                  if (copy_n == len - 16'd1) begin
                     done_r <= 1'b1;
                     st     <= LS_IDLE;
                  end
               end
            end

            default: st <= LS_IDLE;
         endcase
      end
   end

   assign ram_we      = (st == LS_COPY) && rsp_valid;
   assign ram_addr    = dst_r + RAM_AW'(copy_n);
   assign ram_wdata   = rsp_data;
   assign busy        = (st != LS_IDLE);
   assign done        = done_r;
   assign error       = err_r;
   assign entry_count = count_r;

endmodule

// File: rtl/cart_loader_chk.sv
module cart_loader_chk #(
   parameter int RAM_AW    = 12,
   parameter int RAM_BYTES = 4096
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              rom_rd,
   input logic              ram_we,
   input logic [RAM_AW-1:0] ram_addr,
   input logic              busy,
   input logic              done,
   input logic              error
);

   AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ({1'b0, ram_addr} < (RAM_AW+1)'(RAM_BYTES))); // R7

   AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error)); // R10

   AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> busy); // R6

   AST_SINGLE_ROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rom_rd |=> !rom_rd); // R11

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done); // R10

   AST_NO_STATUS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(done || error)); // R10

endmodule

bind cart_loader cart_loader_chk #(
   .RAM_AW    (RAM_AW),
   .RAM_BYTES (RAM_BYTES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .rom_rd   (rom_rd),
   .ram_we   (ram_we),
   .ram_addr (ram_addr),
   .busy     (busy),
   .done     (done),
   .error    (error)
);

// File: tb/cart_loader_test.sv
module cart_loader_test;

   localparam int ROM_AW    = 16;
   localparam int RAM_AW    = 8;
   localparam int RAM_BYTES = 200;
   localparam int NAME_LEN  = 8;
   localparam int ROM_LAT   = 2;
   localparam int ES        = 4 + NAME_LEN + 1;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  start = 1'b0;
   logic                  load = 1'b0;
   logic [7:0]            sel = '0;
   logic [RAM_AW-1:0]     dst_base = '0;
   logic                  rom_rd;
   logic [ROM_AW-1:0]     rom_addr;
   logic [7:0]            rom_data;
   logic                  ram_we;
   logic [RAM_AW-1:0]     ram_addr;
   logic [7:0]            ram_wdata;
   logic                  busy, done, error;
   logic [7:0]            entry_count;
   logic [NAME_LEN*8-1:0] name_bytes;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   cart_loader #(
      .ROM_AW(ROM_AW), .RAM_AW(RAM_AW), .RAM_BYTES(RAM_BYTES),
      .NAME_LEN(NAME_LEN), .HAS_ATTR(1), .ROM_LAT(ROM_LAT)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .load(load), .sel(sel),
      .dst_base(dst_base), .rom_rd(rom_rd), .rom_addr(rom_addr),
      .rom_data(rom_data), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .busy(busy), .done(done), .error(error),
      .entry_count(entry_count), .name_bytes(name_bytes)
   );

   // ---------------- cartridge ROM model ----------------
   // Entries: 0 @0x0100 len 5 visible; 1 @0x0200 len 3 hidden;
   //          2 @0x0300 len 0 visible; 3 @0x0400 len 20 visible.
   logic [7:0] dir_mem [0:63];

   function automatic logic [7:0] name_byte(int e, int k);
      return 8'(8'h41 + e * 16 + k);
   endfunction

   function automatic logic [NAME_LEN*8-1:0] name_of(int e);
      logic [NAME_LEN*8-1:0] v;
      for (int k = 0; k < NAME_LEN; k++) v[8*k +: 8] = name_byte(e, k);
      return v;
   endfunction

   function automatic logic [7:0] pat(logic [15:0] a);
      return 8'(a[7:0] + a[15:8] * 8'd37);
   endfunction

   function automatic logic [7:0] rom_byte(logic [15:0] a);
      if (a < 16'd64) return dir_mem[a[5:0]];
      return pat(a);
   endfunction

   initial begin
      int lens [4];
      int attr [4];
      lens = '{5, 3, 0, 20};
      attr = '{0, 1, 0, 0};
      for (int i = 0; i < 64; i++) dir_mem[i] = 8'hEE;
      dir_mem[0] = 8'd4;
      for (int e = 0; e < 4; e++) begin
         int b;
         b = 1 + e * ES;
         dir_mem[b]     = 8'h00;
         dir_mem[b + 1] = 8'(e + 1);
         dir_mem[b + 2] = 8'(lens[e]);
         dir_mem[b + 3] = 8'h00;
         for (int k = 0; k < NAME_LEN; k++) dir_mem[b + 4 + k] = name_byte(e, k);
         dir_mem[b + 4 + NAME_LEN] = 8'(attr[e]);
      end
   end

   logic [7:0] rq0, rq1;
   always @(posedge clk) begin
      if (rom_rd) rq0 <= rom_byte(rom_addr);
      rq1 <= rq0;
   end
   assign rom_data = rq1;

   // ---------------- scoreboard ----------------
   typedef struct packed {
      logic [RAM_AW-1:0] addr;
      logic [7:0]        data;
   } wr_item_t;

   wr_item_t exp_q [$];
   logic     prev_rd = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (rom_rd && prev_rd)
            check(1'b0, "R11", "rom_rd in consecutive cycles", 64'd1, 64'd0);
         prev_rd <= rom_rd;
         if (ram_we) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5/R7/R8/R9", "unexpected RAM write addr", 64'(ram_addr), 64'hFFFF);
            end else begin
               wr_item_t it;
               it = exp_q.pop_front();
               check(ram_addr == it.addr, "R6", "write address", 64'(ram_addr), 64'(it.addr));
               check(ram_wdata == it.data, "R6", "write data", 64'(ram_wdata), 64'(it.data));
            end
         end
      end
   end

   // push the writes a good copy of entry e to dst must make
   task automatic expect_copy(input int e, input int dst, input int n);
      for (int k = 0; k < n; k++) begin
         wr_item_t it;
         it.addr = RAM_AW'(dst + k);
         it.data = pat(16'((e + 1) * 256 + k));
         exp_q.push_back(it);
      end
   endtask

   task automatic wait_idle();
      int guard;
      guard = 0;
      @(negedge clk);
      while (busy && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic run_cmd(input bit ld, input int s, input int dst, input bit inject);
      @(negedge clk);
      load = ld; sel = 8'(s); dst_base = RAM_AW'(dst); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (inject) begin
         repeat (3) @(negedge clk);
         load = 1'b1; sel = 8'd2; dst_base = RAM_AW'(0); start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait_idle();
   endtask

   task automatic check_end(input string req, input bit exp_done, input bit exp_err,
                            input int exp_cnt);
      check(done == exp_done, req, "done", 64'(done), 64'(exp_done));
      check(error == exp_err, req, "error", 64'(error), 64'(exp_err));
      check(entry_count == 8'(exp_cnt), req, "entry_count", 64'(entry_count), 64'(exp_cnt));
      check(exp_q.size() == 0, req, "pending expected writes", 64'(exp_q.size()), 64'd0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "WDOG", "watchdog expired", 64'd1, 64'd0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy && !done && !error, "R1", "status after reset",
            64'({busy, done, error}), 64'd0);
      check(!ram_we && !rom_rd, "R1", "strobes after reset", 64'({ram_we, rom_rd}), 64'd0);
      check(entry_count == 8'd0, "R1", "entry_count after reset", 64'(entry_count), 64'd0);
      check(name_bytes == '0, "R1", "name after reset", name_bytes, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R9 look-only, R3 visible count, R4/R2 name of entry 0
      run_cmd(1'b0, 0, 0, 1'b0);
      check_end("R9", 1'b1, 1'b0, 3);
      check(name_bytes == name_of(0), "R4", "name of visible 0", name_bytes, name_of(0));

      // R6 copy of entry 0 to address 10
      expect_copy(0, 10, 5);
      run_cmd(1'b1, 0, 10, 1'b0);
      check_end("R6", 1'b1, 1'b0, 3);

      // R3 visible index 1 skips hidden entry 1, lands on zero-length entry 2 (R8)
      run_cmd(1'b1, 1, 0, 1'b0);
      check_end("R8", 1'b1, 1'b0, 3);
      check(name_bytes == name_of(2), "R3", "hidden entry skipped", name_bytes, name_of(2));

      // R7 exact fit at the top of RAM
      expect_copy(3, 180, 20);
      run_cmd(1'b1, 2, 180, 1'b0);
      check_end("R7", 1'b1, 1'b0, 3);
      check(name_bytes == name_of(3), "R4", "name of visible 2", name_bytes, name_of(3));

      // R7 one byte over: refused, no writes
      run_cmd(1'b1, 2, 181, 1'b0);
      check_end("R7", 1'b0, 1'b1, 3);

      // R5 index equal to the count, and the largest index
      run_cmd(1'b1, 3, 0, 1'b0);
      check_end("R5", 1'b0, 1'b1, 3);
      run_cmd(1'b1, 255, 0, 1'b0);
      check_end("R5", 1'b0, 1'b1, 3);

      // R10 start while busy ignored: result is that of the first command
      expect_copy(0, 50, 5);
      run_cmd(1'b1, 0, 50, 1'b1);
      check_end("R10", 1'b1, 1'b0, 3);
      check(name_bytes == name_of(0), "R10", "name kept from first command",
            name_bytes, name_of(0));

      // R10 status held while idle
      repeat (10) @(negedge clk);
      check(done && !error, "R10", "done held", 64'({done, error}), 64'b10);

      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule